// File: doc/BRIEF.md
# Burst Register Window Redirector

This block sits in front of a small bank of 16-bit control registers and gives a DMA engine one fixed bus address through which it can reach a run of consecutive registers. Software programs a burst setup word that holds a starting register number and a transfer count. Each later read or write to the data-port address is steered to the register at the start position plus a running index. The index then moves on by one, so a DMA engine that repeatedly hits a single address walks through the whole run.

When the index reaches the programmed count it returns to zero, and the next data-port access starts a new pass over the same registers. Writing the setup word resets the index. Targets that fall outside the register bank are not acted on, but they still use up an index step. Ordinary accesses to the bank bypass the redirector and leave the index where it is.

The bus is a simple synchronous strobe bus with byte addresses and word registers four bytes apart.

Top module: `dbr_window_top`

## Requirements
- R1: After reset every bank register, the setup word and the index are zero, and reads of 0x00, 0x44, 0x48 and 0x4C all return 0x0000.
- R2: The setup word lives at byte 0x48. It holds the length in bits 12:8 and the start register in bits 4:0. Bits 15:13 and 7:5 read as zero whatever was written to them.
- R3: A written length above 17 is stored and read back as 17. A length value n means n+1 transfers.
- R4: A read or write at byte 0x4C reaches the 16-bit bank register numbered start+index, which sits at byte (start+index)*4. Every such access moves the index up by one.
- R5: The access made with index equal to the length returns the index to 0, so the next data-port access targets the start register again.
- R6: Any write to the setup word sets the index to 0, including in the middle of a pass.
- R7: A data-port target numbered 18 or higher is not acted on. A write to it changes nothing, including the setup word. A read from it returns 0x0000. The index still advances.
- R8: Bank registers 0..17 at bytes 0x00..0x44 read and write directly, and these accesses leave the index unchanged.
- R9: Read data is registered. It appears the cycle after the read strobe and holds until the next read. Address bits 1:0 are ignored. Unmapped addresses read 0x0000 and ignore writes. A write strobe takes priority over a read strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |

## Verification
The bench drives passes that wrap, so a design that does not wrap, or wraps one access early or late, writes the wrong register on the fourth transfer. It places a pass across the bank's end so that the steps fall on the setup word and the data port itself. A design that lets those targets through would corrupt the setup word, and one that stalls the index would return the wrong data on the next read. It also writes the setup word in the middle of a pass, writes an out-of-range length, and interleaves direct accesses between port accesses; a design that misses the reset, the clamp or the rule that direct accesses leave the index alone reads back a shifted register. Register-level checks cover the read latency and hold, the reserved bits and the address aliasing.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int FLD_W = 5;
  localparam int TGT_W = FLD_W + 1;

  typedef logic [FLD_W-1:0] fld_t;
  typedef logic [TGT_W-1:0] tgt_t;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } bus_op_e;

  // Length above the limit saturates at the limit.
  function automatic fld_t clamp_len(fld_t raw, fld_t lim);
    return (raw > lim) ? lim : raw;
  endfunction

  // Index after one port access: wraps once the length is reached.
  function automatic fld_t next_index(fld_t cur, fld_t len);
    fld_t one;
    one = '0;
    one[0] = 1'b1;
    return (cur >= len) ? '0 : fld_t'(cur + one);
  endfunction

  // Register number hit by a port access, one bit wider to avoid overflow.
  function automatic tgt_t burst_target(fld_t base, fld_t idx);
    return {1'b0, base} + {1'b0, idx};
  endfunction

  // Strobe decode with write priority.
  function automatic bus_op_e decode_op(logic rd, logic wr);
    if (wr) return OP_WRITE;
    if (rd) return OP_READ;
    return OP_IDLE;
  endfunction
endpackage

// File: rtl/dbr_cfg_reg.sv
module dbr_cfg_reg
  import dbr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int LEN_LSB  = 8,
  parameter int BASE_LSB = 0,
  parameter int MAX_LEN  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] wdata,
  output fld_t              len,
  output fld_t              base,
  output logic [DATA_W-1:0] cfg_word
);
  localparam fld_t LIMIT = fld_t'(MAX_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len  <= '0;
      base <= '0;
    end else if (cfg_we) begin
      len  <= clamp_len(wdata[LEN_LSB +: FLD_W], LIMIT);
      base <= wdata[BASE_LSB +: FLD_W];
    end
  end

  // Only the two fields are stored; every other bit reads zero.
  always_comb begin
    cfg_word = '0;
    cfg_word[LEN_LSB +: FLD_W]  = len;
    cfg_word[BASE_LSB +: FLD_W] = base;
  end
endmodule

// File: rtl/dbr_index_seq.sv
module dbr_index_seq
  import dbr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  fld_t len,
  output fld_t idx,
  output logic wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (clr)  idx <= '0;
    else if (step) idx <= next_index(idx, len);
  end

  assign wrap = step && (idx >= len);
endmodule

// File: rtl/dbr_addr_map.sv
module dbr_addr_map
  import dbr_pkg::*;
#(
  parameter int WIDX_W    = 6,
  parameter int EIDX_W    = 6,
  parameter int NUM_REGS  = 18,
  parameter int CFG_WIDX  = 18,
  parameter int PORT_WIDX = 19
) (
  input  logic [WIDX_W-1:0]   word_idx,
  input  logic                wr_act,
  input  fld_t                base,
  input  fld_t                idx,
  output logic                is_cfg,
  output logic                is_port,
  output logic                tgt_ok,
  output logic [EIDX_W-1:0]   eff_idx,
  output logic                eff_ok,
  output logic [NUM_REGS-1:0] we_vec
);
  localparam logic [WIDX_W-1:0] CFG_W  = WIDX_W'(CFG_WIDX);
  localparam logic [WIDX_W-1:0] PORT_W = WIDX_W'(PORT_WIDX);
  localparam logic [EIDX_W-1:0] NREG_E = EIDX_W'(NUM_REGS);

  tgt_t              tgt;
  logic [EIDX_W-1:0] tgt_e;
  logic [EIDX_W-1:0] direct_e;

  assign is_cfg   = (word_idx == CFG_W);
  assign is_port  = (word_idx == PORT_W);
  assign tgt      = burst_target(base, idx);
  assign tgt_e    = EIDX_W'(tgt);
  assign direct_e = EIDX_W'(word_idx);
  assign tgt_ok   = (tgt_e < NREG_E);

  always_comb begin
    if (is_port) begin
      eff_idx = tgt_e;
      eff_ok  = tgt_ok;
    end else begin
      eff_idx = direct_e;
      eff_ok  = (direct_e < NREG_E);
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_we
    assign we_vec[i] = wr_act && eff_ok && (eff_idx == EIDX_W'(i));
  end
endmodule

// File: rtl/dbr_regfile.sv
module dbr_regfile #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 18,
  parameter int EIDX_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] we_vec,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [EIDX_W-1:0]   rsel,
  output logic [DATA_W-1:0]   rword
);
  logic [NUM_REGS*DATA_W-1:0] flat;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (we_vec[i]) q <= wdata;
    end
    assign flat[i*DATA_W +: DATA_W] = q;
  end

  always_comb begin
    rword = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rsel == EIDX_W'(i)) rword = flat[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/dbr_window_top.sv
module dbr_window_top
  import dbr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int NUM_REGS  = 18,
  parameter int MAX_LEN   = 17,
  parameter int CFG_OFFS  = 'h48,
  parameter int PORT_OFFS = 'h4C,
  parameter int LEN_LSB   = 8,
  parameter int BASE_LSB  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam int EIDX_W = (WIDX_W > TGT_W) ? WIDX_W : TGT_W;

  // Bus decode
  bus_op_e           op;
  logic              rd_act, wr_act, bus_acc;
  logic [WIDX_W-1:0] word_idx;
  logic              unused_lsb;

  assign op         = decode_op(bus_rd, bus_wr);
  assign rd_act     = (op == OP_READ);
  assign wr_act     = (op == OP_WRITE);
  assign bus_acc    = rd_act || wr_act;
  assign word_idx   = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];

  // Internal events, named for the checker
  logic                is_cfg, is_port, tgt_ok, eff_ok;
  logic                cfg_we, port_acc, burst_wrap;
  logic [EIDX_W-1:0]   eff_idx;
  logic [NUM_REGS-1:0] we_vec;
  fld_t                burst_len, burst_base, burst_idx;
  logic [DATA_W-1:0]   cfg_word, rf_word;

  assign cfg_we   = wr_act && is_cfg;
  assign port_acc = bus_acc && is_port;

  dbr_cfg_reg #(
    .DATA_W(DATA_W), .LEN_LSB(LEN_LSB), .BASE_LSB(BASE_LSB), .MAX_LEN(MAX_LEN)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .wdata(bus_wdata),
    .len(burst_len), .base(burst_base), .cfg_word(cfg_word)
  );

  dbr_index_seq u_seq (
    .clk(clk), .rst_n(rst_n), .clr(cfg_we), .step(port_acc),
    .len(burst_len), .idx(burst_idx), .wrap(burst_wrap)
  );

  dbr_addr_map #(
    .WIDX_W(WIDX_W), .EIDX_W(EIDX_W), .NUM_REGS(NUM_REGS),
    .CFG_WIDX(CFG_OFFS / 4), .PORT_WIDX(PORT_OFFS / 4)
  ) u_map (
    .word_idx(word_idx), .wr_act(wr_act), .base(burst_base), .idx(burst_idx),
    .is_cfg(is_cfg), .is_port(is_port), .tgt_ok(tgt_ok),
    .eff_idx(eff_idx), .eff_ok(eff_ok), .we_vec(we_vec)
  );

  dbr_regfile #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .EIDX_W(EIDX_W)
  ) u_rf (
    .clk(clk), .rst_n(rst_n), .we_vec(we_vec), .wdata(bus_wdata),
    .rsel(eff_idx), .rword(rf_word)
  );

  // Registered read path: updated only by a read strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_act) begin
      if (is_cfg)      bus_rdata <= cfg_word;
      else if (eff_ok) bus_rdata <= rf_word;
      else             bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/dbr_window_chk.sv
module dbr_window_chk
  import dbr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 18,
  parameter int MAX_LEN  = 17,
  parameter int LEN_LSB  = 8,
  parameter int BASE_LSB = 0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rd_act,
  input logic                wr_act,
  input logic                is_cfg,
  input logic                is_port,
  input logic                tgt_ok,
  input logic                cfg_we,
  input logic                port_acc,
  input logic                burst_wrap,
  input fld_t                burst_idx,
  input fld_t                burst_len,
  input logic [NUM_REGS-1:0] we_vec,
  input logic [DATA_W-1:0]   bus_rdata
);
  localparam fld_t LIMIT = fld_t'(MAX_LEN);
  localparam fld_t ONE   = fld_t'(1);

  function automatic logic [DATA_W-1:0] field_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    m[LEN_LSB +: FLD_W]  = '1;
    m[BASE_LSB +: FLD_W] = '1;
    return m;
  endfunction
  localparam logic [DATA_W-1:0] FMASK = field_mask();

  p_len_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    burst_len <= LIMIT);

  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_idx <= burst_len);

  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_acc && !burst_wrap) |=> (burst_idx == $past(burst_idx) + ONE));

  p_idx_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_wrap |=> (burst_idx == '0));

  p_cfg_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (burst_idx == '0));

  p_oob_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act && is_port && !tgt_ok) |-> (we_vec == '0));

  p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));

  p_direct_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_act || wr_act) && !is_port && !cfg_we) |=> $stable(burst_idx));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && is_cfg) |=> ((bus_rdata & ~FMASK) == '0));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |=> $stable(bus_rdata));
endmodule

bind dbr_window_top dbr_window_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .MAX_LEN(MAX_LEN),
  .LEN_LSB(LEN_LSB), .BASE_LSB(BASE_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .wr_act(wr_act),
  .is_cfg(is_cfg), .is_port(is_port), .tgt_ok(tgt_ok), .cfg_we(cfg_we),
  .port_acc(port_acc), .burst_wrap(burst_wrap), .burst_idx(burst_idx),
  .burst_len(burst_len), .we_vec(we_vec), .bus_rdata(bus_rdata)
);

// File: tb/test_dbr_window_top.sv
module test_dbr_window_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dbr_window_top i_dbr_window_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [15:0] val;   // write data, or expected read data
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h48, 16'h0201, 4'd4}, // R4 len 2 (3 transfers), start 1
    '{1'b1, 8'h4C, 16'hA001, 4'd4}, // R4 -> reg1
    '{1'b1, 8'h4C, 16'hA002, 4'd4}, // R4 -> reg2
    '{1'b1, 8'h4C, 16'hA003, 4'd5}, // R5 -> reg3, wrap
    '{1'b1, 8'h4C, 16'hA004, 4'd5}, // R5 -> reg1 again
    '{1'b0, 8'h04, 16'hA004, 4'd5}, // R5
    '{1'b0, 8'h08, 16'hA002, 4'd4}, // R4
    '{1'b0, 8'h0C, 16'hA003, 4'd4}, // R4
    '{1'b0, 8'h48, 16'h0201, 4'd2}, // R2
    '{1'b0, 8'h4C, 16'hA002, 4'd4}, // R4 port read, reg2
    '{1'b0, 8'h4C, 16'hA003, 4'd4}, // R4 reg3
    '{1'b0, 8'h4C, 16'hA004, 4'd5}, // R5 wrapped to reg1
    '{1'b1, 8'h48, 16'hFFFF, 4'd3}, // R3 oversize length
    '{1'b0, 8'h48, 16'h111F, 4'd3}, // R3 clamped to 17, start 31
    '{1'b1, 8'h4C, 16'h5555, 4'd7}, // R7 target 31 dropped
    '{1'b0, 8'h4C, 16'h0000, 4'd7}, // R7 target 32 reads zero
    '{1'b1, 8'h48, 16'hE0E0, 4'd2}, // R2 only reserved bits set
    '{1'b0, 8'h48, 16'h0000, 4'd2}, // R2
    '{1'b1, 8'h48, 16'h0110, 4'd4}, // R4 len 1, start 16
    '{1'b1, 8'h4C, 16'h1616, 4'd4}, // R4 -> reg16
    '{1'b1, 8'h4C, 16'h1717, 4'd4}, // R4 -> reg17
    '{1'b0, 8'h40, 16'h1616, 4'd8}, // R8
    '{1'b0, 8'h44, 16'h1717, 4'd8}, // R8
    '{1'b1, 8'h48, 16'h0211, 4'd7}, // R7 len 2, start 17
    '{1'b1, 8'h4C, 16'hB017, 4'd7}, // R7 -> reg17
    '{1'b1, 8'h4C, 16'hB018, 4'd7}, // R7 target 18 (setup) dropped
    '{1'b1, 8'h4C, 16'hB019, 4'd7}, // R7 target 19 (port) dropped
    '{1'b0, 8'h48, 16'h0211, 4'd7}, // R7 setup untouched
    '{1'b0, 8'h44, 16'hB017, 4'd7}, // R7
    '{1'b0, 8'h4C, 16'hB017, 4'd7}, // R7 index advanced over drops
    '{1'b0, 8'h4C, 16'h0000, 4'd7}, // R7 target 18 reads zero
    '{1'b1, 8'h48, 16'h0211, 4'd6}, // R6 mid-pass setup write
    '{1'b0, 8'h4C, 16'hB017, 4'd6}, // R6 restarted at reg17
    '{1'b1, 8'h00, 16'h0C0C, 4'd8}, // R8
    '{1'b1, 8'h04, 16'h0D0D, 4'd8}, // R8
    '{1'b1, 8'h48, 16'h0100, 4'd8}, // R8 len 1, start 0
    '{1'b0, 8'h4C, 16'h0C0C, 4'd8}, // R8 reg0
    '{1'b1, 8'h08, 16'hEEEE, 4'd8}, // R8 direct write between port hits
    '{1'b0, 8'h08, 16'hEEEE, 4'd8}, // R8
    '{1'b0, 8'h4C, 16'h0D0D, 4'd8}, // R8 index not moved: reg1
    '{1'b0, 8'h0B, 16'hEEEE, 4'd9}, // R9 low bits ignored
    '{1'b0, 8'h80, 16'h0000, 4'd9}, // R9 unmapped
    '{1'b1, 8'h80, 16'h1234, 4'd9}, // R9 unmapped write
    '{1'b0, 8'h80, 16'h0000, 4'd9}  // R9
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic do_write(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rdata", bus_rdata, 16'h0000);
    do_read(8'h48, rv); check("R1 setup", rv, 16'h0000);
    do_read(8'h44, rv); check("R1 reg17", rv, 16'h0000);
    do_read(8'h00, rv); check("R1 reg0", rv, 16'h0000);
    do_read(8'h4C, rv); check("R1 port", rv, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        do_write(VEC[i].addr, VEC[i].val);
      end else begin
        do_read(VEC[i].addr, rv);
        check($sformatf("R%0d vec%0d", VEC[i].req, i), rv, VEC[i].val);
      end
    end

    // R9 latency and hold: setup reads 0x0100, reg0 holds 0x0C0C
    do_read(8'h48, rv);
    check("R9 setup", rv, 16'h0100);
    bus_addr = 8'h00; bus_rd = 1'b1;
    #2;
    check("R9 before edge", bus_rdata, 16'h0100);
    @(negedge clk);
    bus_rd = 1'b0;
    check("R9 after edge", bus_rdata, 16'h0C0C);
    bus_addr = 8'h08;
    repeat (3) @(negedge clk);
    check("R9 hold", bus_rdata, 16'h0C0C);

    // R9 write priority: both strobes -> only a write, index and rdata follow
    bus_addr = 8'h0C; bus_wdata = 16'h7777; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R9 no read on write", bus_rdata, 16'h0C0C);
    do_read(8'h0C, rv); check("R9 written", rv, 16'h7777);

    finish_run();
  end
endmodule